// File: doc/BRIEF.md
# Register Type-Tag Tracker and Operand Steering

This block keeps one type bit per architectural register. A set bit marks a register that holds a floating-point value. A clear bit marks integer, address or other non-floating-point data. Each decoded instruction arrives as a small class code with a destination index and two source indices. The block reads the source tags in the same cycle and decides whether the shared opcode goes to the integer unit or to the floating-point unit. It also decides which tag the destination receives. The tag store is updated at the next clock edge.

When the two source tags of a shared arithmetic opcode disagree, a two-bit policy input selects what happens:
- raise a type-mismatch exception;
- follow source 1 and convert source 2;
- force floating point and convert the integer operand;
- follow source 1 with no conversion.

A bulk port serves procedure entry, procedure exit and context switches. The save side shows all tags as one word. The restore side rewrites only the tags of the registers named in a mask. Arithmetic, number conversion and memory access are left to other blocks; this block only produces tags and routing decisions.

Top module: `regtag_steer`

## Requirements
- R1: After reset every tag is clear. `save_word` bit i always shows the current tag of register i.
- R2: Class 1 (floating-point load, single or double) sets the tag of `dec_dst`. Class 2 (non-floating-point load of any size) clears it. Neither class asserts `sel_int` or `sel_fp`.
- R3: Class 3 (shared arithmetic: add, subtract, multiply, divide, max, min, absolute value, compare) with equal source tags asserts `sel_fp` when the tags are set and `sel_int` when they are clear. It writes that tag to `dec_dst`, drives it on `res_tag`, and does not request conversion.
- R4: Class 3 with differing source tags under policy 0 asserts `mis_exc` and drives the source indices on `mis_src_a` and `mis_src_b`. It deasserts both unit selects and leaves all tags unchanged.
- R5: Class 3 with differing tags under policy 1 follows source 1's tag for the unit and the destination tag. It asserts `cvt_req` with `cvt_which`=1 (source 2).
- R6: Class 3 with differing tags under policy 2 always selects the floating-point unit and sets the destination tag. It asserts `cvt_req`, with `cvt_which` naming the integer operand (0 = source 1, 1 = source 2).
- R7: Class 3 with differing tags under policy 3 follows source 1's tag for the unit and the destination tag, without conversion.
- R8: Class 4 (tag-resolved single-source operation: a floating-point-only function when set, an integer-only function such as population count, find-first-one or shift when clear) selects the unit named by source 1's tag. It gives the destination that same tag.
- R9: Class 5 (bitwise OR) checks two idioms, in this order. When `dec_dst`, `dec_src1` and `dec_src2` are all equal, it sets that register's tag. When `dec_src2`=0 and `dec_dst`=`dec_src1`, it clears that tag. Neither idiom selects a unit. Any other OR goes to the integer unit and clears the destination tag.
- R10: A restore (`rest_en`) changes, at the next edge, exactly the tags whose `rest_mask` bit is 1, to the matching `rest_word` bits. All other tags keep their value.
- R11: At most one single-register update occurs per cycle. When it coincides with a restore, the single update decides its register's tag.
- R12: Classes 0, 6 and 7 select no unit, raise nothing and change no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction present |
| dec_class | input | 3 | Instruction class code |
| dec_dst | input | 5 | Destination register index |
| dec_src1 | input | 5 | Source 1 register index |
| dec_src2 | input | 5 | Source 2 register index |
| mix_policy | input | 2 | Policy for differing source tags |
| rest_en | input | 1 | Bulk restore strobe |
| rest_mask | input | 32 | Registers whose tags are restored |
| rest_word | input | 32 | Tag values to restore |
| save_word | output | 32 | Current tags of all registers |
| sel_int | output | 1 | Route to integer unit |
| sel_fp | output | 1 | Route to floating-point unit |
| res_tag | output | 1 | Tag written to destination (0 when none) |
| cvt_req | output | 1 | Operand conversion requested |
| cvt_which | output | 1 | Operand to convert: 0 source 1, 1 source 2 |
| mis_exc | output | 1 | Type-mismatch exception |
| mis_src_a | output | 5 | Source 1 index of a mismatch |
| mis_src_b | output | 5 | Source 2 index of a mismatch |

## Verification
Some properties are checked on every cycle:
- the two unit selects are never asserted together;
- an exception never coincides with a unit select or a conversion request;
- a forced-FP conversion always lands on the floating-point unit;
- a single update is visible at the next edge;
- a restore leaves unmasked tags untouched.

Other behaviours only the bench scenarios can show, because they need a tag history built up over many instructions:
- the correct pick of the integer operand under policy 2;
- the ordering between the two OR idioms;
- the suppressed write on an exception;
- a single update winning over a coinciding restore.

// File: rtl/regtag_pkg.sv
// Shared class codes and the routing decision record.
// Assumes the decoder has already mapped opcodes onto these classes.
package regtag_pkg;
    typedef enum logic [2:0] {
        CL_NOP    = 3'd0,
        CL_LD_FP  = 3'd1,
        CL_LD_INT = 3'd2,
        CL_ARITH  = 3'd3,
        CL_UNARY  = 3'd4,
        CL_OR     = 3'd5
    } op_class_e;

    typedef enum logic [1:0] {
        POL_TRAP   = 2'd0,
        POL_SRC1CV = 2'd1,
        POL_FORCEF = 2'd2,
        POL_SRC1NC = 2'd3
    } mix_policy_e;

    typedef struct packed {
        logic sel_int;
        logic sel_fp;
        logic wr_en;
        logic wr_val;
        logic cvt_req;
        logic cvt_which;
        logic exc;
    } route_t;
endpackage

// File: rtl/regtag_file.sv
// Tag store: one flop per register with combinational reads.
// Applies a masked bulk restore, then one single-register update that overrides it.
// Assumes at most one single update per cycle.
module regtag_file #(
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic            wr_val,
    input  logic            bulk_en,
    input  logic [NREG-1:0] bulk_mask,
    input  logic [NREG-1:0] bulk_word,
    input  logic [IW-1:0]   rd_a_idx,
    input  logic [IW-1:0]   rd_b_idx,
    output logic            rd_a,
    output logic            rd_b,
    output logic [NREG-1:0] tags
);
    // One flop per tag; the single update takes priority over the bulk restore.
    for (genvar g = 0; g < NREG; g++) begin : g_bit
        logic hit_single;
        logic hit_bulk;
        assign hit_single = wr_en && (wr_idx == IW'(g));
        assign hit_bulk   = bulk_en && bulk_mask[g];
        // Update one tag bit.
        always_ff @(posedge clk) begin
            if (!rst_n)          tags[g] <= 1'b0;
            else if (hit_single) tags[g] <= wr_val;
            else if (hit_bulk)   tags[g] <= bulk_word[g];
        end
    end

    // Combinational read ports for same-cycle steering.
    always_comb begin
        rd_a = tags[rd_a_idx];
        rd_b = tags[rd_b_idx];
    end

    // R11
    single_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> tags[$past(wr_idx)] == $past(wr_val));

    // R10
    bulk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bulk_en) && !$past(wr_en)) |->
        ((tags & ~$past(bulk_mask)) == ($past(tags) & ~$past(bulk_mask))));
endmodule

// File: rtl/regtag_resolve.sv
// Pure decision logic: class, source tags and policy in, one routing record out.
// Assumes the source tags are read in the same cycle from the tag store.
module regtag_resolve
    import regtag_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          valid,
    input  logic [2:0]    cls,
    input  logic [IW-1:0] dst,
    input  logic [IW-1:0] src1,
    input  logic [IW-1:0] src2,
    input  logic          t1,
    input  logic          t2,
    input  logic [1:0]    policy,
    output route_t        rt
);
    // Resolve the unit, the destination tag and the conversion for one instruction.
    always_comb begin
        rt = '0;
        if (valid) begin
            unique case (cls)
                CL_LD_FP:  begin rt.wr_en = 1'b1; rt.wr_val = 1'b1; end
                CL_LD_INT: begin rt.wr_en = 1'b1; rt.wr_val = 1'b0; end
                CL_ARITH: begin
                    if (t1 == t2) begin
                        rt.wr_en = 1'b1; rt.wr_val = t1;
                    end else begin
                        unique case (policy)
                            POL_TRAP: rt.exc = 1'b1;
                            POL_SRC1CV: begin
                                rt.wr_en = 1'b1; rt.wr_val = t1;
                                rt.cvt_req = 1'b1; rt.cvt_which = 1'b1;
                            end
                            POL_FORCEF: begin
                                rt.wr_en = 1'b1; rt.wr_val = 1'b1;
                                rt.cvt_req = 1'b1; rt.cvt_which = t1;
                            end
                            default: begin rt.wr_en = 1'b1; rt.wr_val = t1; end
                        endcase
                    end
                    rt.sel_fp  = rt.wr_en && rt.wr_val;
                    rt.sel_int = rt.wr_en && !rt.wr_val;
                end
                CL_UNARY: begin
                    rt.wr_en = 1'b1; rt.wr_val = t1;
                    rt.sel_fp = t1; rt.sel_int = !t1;
                end
                CL_OR: begin
                    rt.wr_en = 1'b1;
                    if (dst == src1 && src1 == src2) rt.wr_val = 1'b1;
                    else if (dst == src1 && src2 == '0) rt.wr_val = 1'b0;
                    else begin rt.wr_val = 1'b0; rt.sel_int = 1'b1; end
                end
                default: rt = '0;
            endcase
        end
    end
endmodule

// File: rtl/regtag_steer.sv
// Top: tag store plus resolver; outputs route decisions in the decode cycle
// and commits the destination tag at the next edge. Assumes one instruction per cycle.
module regtag_steer
    import regtag_pkg::*;
#(
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [2:0]      dec_class,
    input  logic [IW-1:0]   dec_dst,
    input  logic [IW-1:0]   dec_src1,
    input  logic [IW-1:0]   dec_src2,
    input  logic [1:0]      mix_policy,
    input  logic            rest_en,
    input  logic [NREG-1:0] rest_mask,
    input  logic [NREG-1:0] rest_word,
    output logic [NREG-1:0] save_word,
    output logic            sel_int,
    output logic            sel_fp,
    output logic            res_tag,
    output logic            cvt_req,
    output logic            cvt_which,
    output logic            mis_exc,
    output logic [IW-1:0]   mis_src_a,
    output logic [IW-1:0]   mis_src_b
);
    logic   t1, t2;
    route_t rt;

    regtag_file #(.NREG(NREG)) u_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rt.wr_en), .wr_idx(dec_dst), .wr_val(rt.wr_val),
        .bulk_en(rest_en), .bulk_mask(rest_mask), .bulk_word(rest_word),
        .rd_a_idx(dec_src1), .rd_b_idx(dec_src2),
        .rd_a(t1), .rd_b(t2), .tags(save_word)
    );

    regtag_resolve #(.NREG(NREG)) u_res (
        .valid(dec_valid), .cls(dec_class), .dst(dec_dst),
        .src1(dec_src1), .src2(dec_src2), .t1(t1), .t2(t2),
        .policy(mix_policy), .rt(rt)
    );

    // Drive the outward decision ports from the routing record.
    always_comb begin
        sel_int   = rt.sel_int;
        sel_fp    = rt.sel_fp;
        res_tag   = rt.wr_en && rt.wr_val;
        cvt_req   = rt.cvt_req;
        cvt_which = rt.cvt_which;
        mis_exc   = rt.exc;
        mis_src_a = rt.exc ? dec_src1 : '0;
        mis_src_b = rt.exc ? dec_src2 : '0;
    end

    // R3
    unit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_int, sel_fp}));

    // R4
    exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mis_exc |-> (!sel_int && !sel_fp && !cvt_req));

    // R4
    exc_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mis_exc |=> $stable(save_word) || $past(rest_en));

    // R6
    force_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_req && mix_policy == 2'd2) |-> (sel_fp && (t1 != t2)));

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid || dec_class > 3'd5 || dec_class == 3'd0) |-> (!sel_int && !sel_fp && !mis_exc));
endmodule

// File: tb/test_regtag_steer.sv
module test_regtag_steer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_valid;
    logic [2:0]  dec_class;
    logic [4:0]  dec_dst, dec_src1, dec_src2;
    logic [1:0]  mix_policy;
    logic        rest_en;
    logic [31:0] rest_mask, rest_word;
    logic [31:0] save_word;
    logic        sel_int, sel_fp, res_tag, cvt_req, cvt_which, mis_exc;
    logic [4:0]  mis_src_a, mis_src_b;

    int total = 0;
    int bad   = 0;
    logic [31:0] model;

    always #5 clk = ~clk;

    regtag_steer i_regtag_steer (.*);

    // Expected outputs packed as {sel_int, sel_fp, res_tag, cvt_req, cvt_which, mis_exc, wr, val}.
    function automatic logic [7:0] expect_out(input logic [2:0] c, input logic [4:0] d,
            input logic [4:0] a, input logic [4:0] b, input logic [1:0] p, input logic [31:0] tg);
        logic ta = tg[a];
        logic tb = tg[b];
        logic si = 0, sf = 0, cq = 0, cw = 0, ex = 0, wr = 0, v = 0;
        case (c)
            3'd1: begin wr = 1; v = 1; end
            3'd2: begin wr = 1; v = 0; end
            3'd3: if (ta == tb) begin wr = 1; v = ta; end
                  else if (p == 0) ex = 1;
                  else if (p == 1) begin wr = 1; v = ta; cq = 1; cw = 1; end
                  else if (p == 2) begin wr = 1; v = 1; cq = 1; cw = (ta == 0) ? 1'b0 : 1'b1; end
                  else begin wr = 1; v = ta; end
            3'd4: begin wr = 1; v = ta; end
            3'd5: begin
                wr = 1;
                if (d == a && a == b) v = 1;
                else if (d == a && b == 0) v = 0;
                else begin v = 0; si = 1; end
            end
            default: ;
        endcase
        if (c == 3'd3 || c == 3'd4) begin sf = wr && v; si = wr && !v; end
        return {si, sf, wr && v, cq, cw, ex, wr, v};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, check outputs, then advance the model.
    task automatic step(input logic [2:0] c, input logic [4:0] d, input logic [4:0] a,
            input logic [4:0] b, input logic [1:0] p, input logic re,
            input logic [31:0] rm, input logic [31:0] rw, input string req);
        logic [7:0] e;
        logic [7:0] got;
        @(negedge clk);
        chk(save_word == model, "R1 save_word", save_word, model);
        dec_valid = 1; dec_class = c; dec_dst = d; dec_src1 = a; dec_src2 = b;
        mix_policy = p; rest_en = re; rest_mask = rm; rest_word = rw;
        #2;
        e = expect_out(c, d, a, b, p, model);
        got = {sel_int, sel_fp, res_tag, cvt_req, cvt_which, mis_exc, 2'b00};
        chk(got[7:2] == e[7:2], req, {24'd0, got}, {24'd0, e[7:2], 2'b00});
        if (e[2]) chk(mis_src_a == a && mis_src_b == b, "R4 indices",
                      {22'd0, mis_src_a, mis_src_b}, {22'd0, a, b});
        if (re) model = (model & ~rm) | (rw & rm);
        if (e[1]) model[d] = e[0];
    endtask

    initial begin
        #150000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; dec_valid = 0; dec_class = 0; dec_dst = 0; dec_src1 = 0; dec_src2 = 0;
        mix_policy = 0; rest_en = 0; rest_mask = 0; rest_word = 0;
        model = 32'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk(save_word == 32'd0, "R1 reset", save_word, 32'd0);

        step(3'd1, 5'd3, 0, 0, 0, 0, 0, 0, "R2 fp load");
        step(3'd1, 5'd4, 0, 0, 0, 0, 0, 0, "R2 fp load");
        step(3'd2, 5'd4, 0, 0, 0, 0, 0, 0, "R2 int load");
        step(3'd3, 5'd7, 5'd3, 5'd3, 0, 0, 0, 0, "R3 equal fp");
        step(3'd3, 5'd8, 5'd1, 5'd2, 0, 0, 0, 0, "R3 equal int");
        step(3'd3, 5'd9, 5'd3, 5'd1, 0, 0, 0, 0, "R4 trap");
        step(3'd3, 5'd9, 5'd1, 5'd3, 1, 0, 0, 0, "R5 src1 convert");
        step(3'd3, 5'd10, 5'd1, 5'd3, 2, 0, 0, 0, "R6 force fp src1 int");
        step(3'd3, 5'd11, 5'd3, 5'd1, 2, 0, 0, 0, "R6 force fp src2 int");
        step(3'd3, 5'd12, 5'd1, 5'd3, 3, 0, 0, 0, "R7 src1 no convert");
        step(3'd4, 5'd13, 5'd3, 5'd0, 0, 0, 0, 0, "R8 unary fp");
        step(3'd4, 5'd14, 5'd2, 5'd0, 0, 0, 0, 0, "R8 unary int");
        step(3'd5, 5'd5, 5'd5, 5'd5, 0, 0, 0, 0, "R9 self or sets");
        step(3'd5, 5'd5, 5'd5, 5'd0, 0, 0, 0, 0, "R9 or zero clears");
        step(3'd5, 5'd0, 5'd0, 5'd0, 0, 0, 0, 0, "R9 self idiom first");
        step(3'd5, 5'd6, 5'd3, 5'd7, 0, 0, 0, 0, "R9 plain or");
        step(3'd6, 5'd3, 5'd3, 5'd3, 0, 0, 0, 0, "R12 unused class");
        step(3'd0, 5'd3, 5'd3, 5'd3, 0, 1, 32'h0000_00F0, 32'hFFFF_FFFF, "R10 masked restore");
        step(3'd1, 5'd20, 0, 0, 0, 1, 32'h0010_0000, 32'h0, "R11 single beats restore");
        step(3'd2, 5'd7, 0, 0, 0, 1, 32'h0000_0080, 32'hFFFF_FFFF, "R11 clear beats restore");
        for (int i = 0; i < 3000; i++) begin
            logic re = ($urandom % 8) == 0;
            step(3'($urandom), 5'($urandom), 5'($urandom % 12), 5'($urandom % 12), 2'($urandom),
                 re, $urandom, $urandom, "R3 random mix");
        end
        @(negedge clk);
        chk(save_word == model, "R10 final tags", save_word, model);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule